// File: doc/BRIEF.md
# Reference Input Frequency Classifier

This block finds the carrier frequency of one reference clock. A free-running counter in the reference domain counts rising edges. The counter value crosses into the local free-running clock domain as a Gray code. A fixed window of local-clock cycles takes the difference between two snapshots of that count. The edge count of each window is then classified.

In auto mode the count is compared with thirteen standard telecom and Ethernet rates, and the first rate whose tolerance band holds the count is reported. In manual mode the count is compared with one expected value, N × 8 kHz, where N comes from configuration. Both modes report a signed offset: the measured count minus the expected count.

Measurement never stops. Every window produces a fresh result, so a new carrier, or a lost one, appears without any software action. Downstream qualification logic reads the index, the valid flag and the offset, and updates them on each `meas_done` pulse.

Top module: `ref_freq_classifier`

## Requirements
- R1: While `rst` is high, and after it is released, `freq_idx` reads 4'hF, `freq_valid` reads 0, `freq_offset` reads 0 and `meas_done` reads 0. The first report comes at the end of the second full window after release, never earlier.
- R2: A window lasts `WIN_CYCLES` local cycles. `meas_done` is a one-cycle pulse issued once per window. The outputs change only in the cycle that `meas_done` is high.
- R3: In auto mode (`cfg_manual`=0) the rates are indexed in ascending order: 0:8 kHz, 1:64 kHz, 2:1.544 MHz, 3:2.048 MHz, 4:6.48 MHz, 5:8.192 MHz, 6:16.384 MHz, 7:19.44 MHz, 8:25 MHz, 9:38.88 MHz, 10:50 MHz, 11:77.76 MHz, 12:125 MHz. The expected count of a rate is floor(f_kHz × `WIN_CYCLES` / `LOCAL_KHZ`).
- R4: A count matches a rate when |count − expected| ≤ `cfg_tol`. `freq_offset` is then the signed value count − expected.
- R5: In auto mode, a count that lies in no band gives `freq_idx`=4'hF, `freq_valid`=0 and `freq_offset`=0.
- R6: When the bands of several rates hold the count, the lowest index wins, and the offset is taken against that rate.
- R7: In manual mode (`cfg_manual`=1) the expected count is N × 8 × `WIN_CYCLES` / `LOCAL_KHZ`, with N = `cfg_mult_n`. A count inside the band gives `freq_idx`=4'hE and `freq_valid`=1. A count outside it gives 4'hF and 0. In both cases `freq_offset` carries count − expected.
- R8: In manual mode, N = 0 gives `freq_idx`=4'hF, `freq_valid`=0 and `freq_offset`=0.
- R9: A change of carrier, including a carrier that stops, is fully reflected by the second report after the change. The configuration in force in the cycle before a report is the one that report uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock that times the window |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock under measurement |
| cfg_manual | input | 1 | 0 selects auto table mode, 1 selects N × 8 kHz mode |
| cfg_mult_n | input | 15 | Multiplier N for manual mode |
| cfg_tol | input | TOL_W | Allowed count deviation for a match |
| freq_idx | output | 4 | Rate index 0..12, 4'hE for a manual match, 4'hF for unknown |
| freq_valid | output | 1 | High when the last window matched |
| freq_offset | output | CNT_W+1 | Signed count minus expected count |
| meas_done | output | 1 | One-cycle pulse when the outputs update |

## Verification
The bench goes after four kinds of corner case.

- **Band edges.** A 2.1 MHz carrier falls outside a tolerance of 4 but inside a tolerance of 8. A design with an off-by-one band edge, or one that drops the magnitude of negative offsets, reports the wrong index or valid flag.
- **Overlapping bands.** At 64 kHz with a wide tolerance, both the 8 kHz and 64 kHz bands hold the count. A design that gives the later entry priority answers index 1 instead of 0.
- **Manual mode.** A wrong N must leave the offset visible while valid drops. N = 0 must blank everything. A design that suppresses the offset on a mismatch, or treats N = 0 as a zero-hertz target, fails these.
- **Timing.** A stopped carrier, the exact report spacing and the silent first window after reset catch designs that publish a partial window or miscount the window length.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    localparam int NUM_RATES = 13;
    localparam int N_W = 15;
    localparam logic [3:0] IDX_UNKNOWN = 4'hF;
    localparam logic [3:0] IDX_MANUAL = 4'hE;

    typedef enum logic {
        MODE_AUTO   = 1'b0,
        MODE_MANUAL = 1'b1
    } mode_e;

    typedef struct packed {
        logic [3:0] idx;
        logic       valid;
    } verdict_t;

    // Standard carrier rates in kHz, ascending; index order sets priority.
    function automatic int unsigned rate_khz(input int i);
        case (i)
            0:  return 8;
            1:  return 64;
            2:  return 1544;
            3:  return 2048;
            4:  return 6480;
            5:  return 8192;
            6:  return 16384;
            7:  return 19440;
            8:  return 25000;
            9:  return 38880;
            10: return 50000;
            11: return 77760;
            12: return 125000;
            default: return 0;
        endcase
    endfunction

    function automatic longint unsigned expected_count(input int unsigned khz,
                                                       input int unsigned win,
                                                       input int unsigned local_khz);
        longint unsigned prod;
        prod = longint'(khz) * longint'(win);
        return prod / longint'(local_khz);
    endfunction

    // Width of the edge counter: holds the largest manual count plus one guard bit.
    function automatic int count_width(input int unsigned win, input int unsigned local_khz);
        longint unsigned top;
        int w;
        top = (longint'(32767) * 8 * longint'(win)) / longint'(local_khz);
        w = 1;
        while ((64'd1 << w) <= top) w++;
        return w + 1;
    endfunction

endpackage

// File: rtl/rfc_edge_counter.sv
module rfc_edge_counter
    import rfc_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             ref_clk,
    input  logic             rst,
    output logic [CNT_W-1:0] gray_o
);

    logic [1:0]       rst_pipe;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Reset is brought into the reference domain before use.
    always_ff @(posedge ref_clk) begin
        rst_pipe <= {rst_pipe[0], rst};
    end

    always_ff @(posedge ref_clk) begin
        if (rst_pipe[1]) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    // R2
    gray_step_chk: assert property (@(posedge ref_clk) disable iff (rst_pipe[1])
        $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/rfc_window_meas.sv
module rfc_window_meas
    import rfc_pkg::*;
#(
    parameter int CNT_W      = 19,
    parameter int WIN_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             stb_o
);

    localparam int TMR_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] g_meta;
    logic [CNT_W-1:0] g_sync;
    logic [CNT_W-1:0] bin_now;
    logic [CNT_W-1:0] bin_prev;
    logic [TMR_W-1:0] tmr;
    logic             primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_meta <= '0;
            g_sync <= '0;
        end else begin
            g_meta <= gray_i;
            g_sync <= g_meta;
        end
    end

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            bin_now[i] = ^(g_sync >> i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr      <= '0;
            primed   <= 1'b0;
            bin_prev <= '0;
            cnt_o    <= '0;
            stb_o    <= 1'b0;
        end else begin
            stb_o <= 1'b0;
            if (tmr == TMR_LAST) begin
                tmr      <= '0;
                bin_prev <= bin_now;
                primed   <= 1'b1;
                if (primed) begin
                    cnt_o <= bin_now - bin_prev;
                    stb_o <= 1'b1;
                end
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    // R2
    timer_range_chk: assert property (@(posedge clk) disable iff (rst)
        tmr <= TMR_LAST);

    // R2
    stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);

endmodule

// File: rtl/rfc_classifier.sv
module rfc_classifier
    import rfc_pkg::*;
#(
    parameter int CNT_W      = 19,
    parameter int TOL_W      = 8,
    parameter int WIN_CYCLES = 50000,
    parameter int LOCAL_KHZ  = 50000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stb_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  mode_e                   mode_i,
    input  logic [N_W-1:0]          n_i,
    input  logic [TOL_W-1:0]        tol_i,
    output logic [3:0]              idx_o,
    output logic                    valid_o,
    output logic signed [CNT_W:0]   offset_o,
    output logic                    done_o
);

    localparam int OFF_W = CNT_W + 1;
    localparam int CNT_PER_N = (8 * WIN_CYCLES) / LOCAL_KHZ;

    typedef logic signed [OFF_W-1:0] off_t;

    function automatic off_t diff_of(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        return off_t'({1'b0, a}) - off_t'({1'b0, b});
    endfunction

    function automatic logic [OFF_W-1:0] mag_of(input off_t d);
        off_t neg;
        neg = -d;
        return (d < 0) ? OFF_W'(neg) : OFF_W'(d);
    endfunction

    logic [OFF_W-1:0] tol_x;
    logic [CNT_W-1:0] exp_man;
    verdict_t         auto_v, man_v, next_v;
    off_t             auto_off, man_off, next_off;

    assign tol_x   = OFF_W'(tol_i);
    assign exp_man = CNT_W'(n_i) * CNT_W'(CNT_PER_N);

    // Scan from the top so the lowest matching index is left standing.
    always_comb begin
        off_t d;
        auto_v   = '{idx: IDX_UNKNOWN, valid: 1'b0};
        auto_off = '0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            d = diff_of(cnt_i, CNT_W'(expected_count(rate_khz(i), WIN_CYCLES, LOCAL_KHZ)));
            if (mag_of(d) <= tol_x) begin
                auto_v   = '{idx: 4'(i), valid: 1'b1};
                auto_off = d;
            end
        end
    end

    always_comb begin
        off_t d;
        d = diff_of(cnt_i, exp_man);
        if (n_i == '0) begin
            man_v   = '{idx: IDX_UNKNOWN, valid: 1'b0};
            man_off = '0;
        end else begin
            man_off = d;
            if (mag_of(d) <= tol_x) man_v = '{idx: IDX_MANUAL, valid: 1'b1};
            else                    man_v = '{idx: IDX_UNKNOWN, valid: 1'b0};
        end
    end

    always_comb begin
        if (mode_i == MODE_MANUAL) begin
            next_v   = man_v;
            next_off = man_off;
        end else begin
            next_v   = auto_v;
            next_off = auto_off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o    <= IDX_UNKNOWN;
            valid_o  <= 1'b0;
            offset_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= stb_i;
            if (stb_i) begin
                idx_o    <= next_v.idx;
                valid_o  <= next_v.valid;
                offset_o <= next_off;
            end
        end
    end

    logic [OFF_W-1:0] out_mag;
    assign out_mag = mag_of(offset_o);

    // R3
    valid_idx_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> idx_o != IDX_UNKNOWN);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({idx_o, valid_o, offset_o}));

    // R4
    tol_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && valid_o) |-> out_mag <= OFF_W'($past(tol_i)));

    // R8
    n_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(mode_i == MODE_MANUAL && n_i == '0)) |-> (!valid_o && offset_o == '0));

    // R5
    unknown_auto_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(mode_i == MODE_AUTO) && idx_o == IDX_UNKNOWN) |-> (!valid_o && offset_o == '0));

endmodule

// File: rtl/ref_freq_classifier.sv
module ref_freq_classifier
    import rfc_pkg::*;
#(
    parameter int LOCAL_KHZ  = 50000,
    parameter int WIN_CYCLES = 50000,
    parameter int TOL_W      = 8,
    localparam int CNT_W     = count_width(WIN_CYCLES, LOCAL_KHZ)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_clk,
    input  logic                  cfg_manual,
    input  logic [14:0]           cfg_mult_n,
    input  logic [TOL_W-1:0]      cfg_tol,
    output logic [3:0]            freq_idx,
    output logic                  freq_valid,
    output logic signed [CNT_W:0] freq_offset,
    output logic                  meas_done
);

    logic [CNT_W-1:0] ref_gray;
    logic [CNT_W-1:0] win_cnt;
    logic             win_stb;
    mode_e            mode;

    assign mode = mode_e'(cfg_manual);

    rfc_edge_counter #(
        .CNT_W (CNT_W)
    ) u_edge (
        .ref_clk (ref_clk),
        .rst     (rst),
        .gray_o  (ref_gray)
    );

    rfc_window_meas #(
        .CNT_W      (CNT_W),
        .WIN_CYCLES (WIN_CYCLES)
    ) u_meas (
        .clk    (clk),
        .rst    (rst),
        .gray_i (ref_gray),
        .cnt_o  (win_cnt),
        .stb_o  (win_stb)
    );

    rfc_classifier #(
        .CNT_W      (CNT_W),
        .TOL_W      (TOL_W),
        .WIN_CYCLES (WIN_CYCLES),
        .LOCAL_KHZ  (LOCAL_KHZ)
    ) u_cls (
        .clk      (clk),
        .rst      (rst),
        .stb_i    (win_stb),
        .cnt_i    (win_cnt),
        .mode_i   (mode),
        .n_i      (cfg_mult_n),
        .tol_i    (cfg_tol),
        .idx_o    (freq_idx),
        .valid_o  (freq_valid),
        .offset_o (freq_offset),
        .done_o   (meas_done)
    );

endmodule

// File: tb/ref_freq_classifier_tb.sv
`timescale 1ns/1ps
module ref_freq_classifier_tb;

    localparam int LOCAL_KHZ = 50000;
    localparam int WIN = 6250;
    localparam int TOL_W = 8;
    localparam int OFF_W = rfc_pkg::count_width(WIN, LOCAL_KHZ) + 1;

    typedef struct packed {
        int       khz;
        bit       manual;
        int       n;
        int       tol;
        int       idx;
        bit       valid;
        int       off;
    } vec_t;

    // Expected counts at this window: f_kHz / 8 in auto, N in manual.
    localparam vec_t VECS [12] = '{
        '{2048,   1'b0, 0,    4, 3,  1'b1, 0},  // R3 count 256
        '{1544,   1'b0, 0,    4, 2,  1'b1, 0},  // R3 count 193
        '{125000, 1'b0, 0,    4, 12, 1'b1, 0},  // R3 count 15625
        '{19440,  1'b0, 0,    4, 7,  1'b1, 0},  // R3 count 2430
        '{6480,   1'b0, 0,    4, 4,  1'b1, 0},  // R3 count 810
        '{2100,   1'b0, 0,    4, 15, 1'b0, 0},  // R5 count 262..263, no band
        '{2100,   1'b0, 0,    8, 3,  1'b1, 6},  // R4 inside widened band
        '{2048,   1'b1, 256,  2, 14, 1'b1, 0},  // R7 manual match
        '{2048,   1'b1, 250,  2, 15, 1'b0, 6},  // R7 manual miss, offset kept
        '{2048,   1'b1, 0,    2, 15, 1'b0, 0},  // R8 N of zero
        '{64,     1'b0, 0,    8, 0,  1'b1, 7},  // R6 two bands, lowest wins
        '{50000,  1'b1, 6250, 1, 14, 1'b1, 0}   // R7 manual match high rate
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk = 1'b0;
    logic cfg_manual = 1'b0;
    logic [14:0] cfg_mult_n = '0;
    logic [TOL_W-1:0] cfg_tol = 8'd4;
    logic [3:0] freq_idx;
    logic freq_valid;
    logic signed [OFF_W-1:0] freq_offset;
    logic meas_done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_done = 0;
    int prev_done = 0;
    bit reported = 0;
    real ref_khz = 2048.0;

    ref_freq_classifier #(
        .LOCAL_KHZ  (LOCAL_KHZ),
        .WIN_CYCLES (WIN),
        .TOL_W      (TOL_W)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ref_clk     (ref_clk),
        .cfg_manual  (cfg_manual),
        .cfg_mult_n  (cfg_mult_n),
        .cfg_tol     (cfg_tol),
        .freq_idx    (freq_idx),
        .freq_valid  (freq_valid),
        .freq_offset (freq_offset),
        .meas_done   (meas_done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            if (ref_khz == 0.0) begin
                ref_clk = 1'b0;
                #20;
            end else begin
                #(500000.0 / ref_khz) ref_clk = ~ref_clk;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp, input int slack);
        checks++;
        if (act < exp - slack || act > exp + slack) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (meas_done !== 1'b1);
        prev_done = last_done;
        last_done = cyc;
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
    endtask

    initial begin
        repeat (198000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        string tag;
        int seen;
        repeat (100) @(negedge clk);
        // R1 reset state
        chk("R1", "idx in reset", int'(freq_idx), 15, 0);
        chk("R1", "valid in reset", int'(freq_valid), 0, 0);
        chk("R1", "offset in reset", int'(freq_offset), 0, 0);
        chk("R1", "done in reset", int'(meas_done), 0, 0);
        rst = 1'b0;

        for (int k = 0; k < 12; k++) begin
            cfg_manual = VECS[k].manual;
            cfg_mult_n = 15'(VECS[k].n);
            cfg_tol    = TOL_W'(VECS[k].tol);
            if (k == 0 || real'(VECS[k].khz) != ref_khz) begin
                ref_khz = real'(VECS[k].khz);
                wait_done();
                wait_done();
                // R2 spacing between consecutive reports
                chk("R2", "report spacing", last_done - prev_done, WIN, 0);
            end else begin
                wait_done();
            end
            if (k == 10)                         tag = "R6";
            else if (k == 6)                     tag = "R4";
            else if (VECS[k].manual && VECS[k].n == 0) tag = "R8";
            else if (VECS[k].manual)             tag = "R7";
            else if (!VECS[k].valid)             tag = "R5";
            else                                 tag = "R3";
            chk(tag, $sformatf("vec %0d idx", k), int'(freq_idx), VECS[k].idx, 0);
            chk(tag, $sformatf("vec %0d valid", k), int'(freq_valid), int'(VECS[k].valid), 0);
            chk(tag, $sformatf("vec %0d offset", k), int'(freq_offset), VECS[k].off, 1);
            // R2 outputs held between reports
            @(negedge clk);
            chk("R2", "done width", int'(meas_done), 0, 0);
        end

        // R9 carrier stops: zero count, no band at zero tolerance
        cfg_manual = 1'b0;
        cfg_tol    = '0;
        ref_khz    = 0.0;
        wait_done();
        wait_done();
        chk("R9", "stopped idx", int'(freq_idx), 15, 0);
        chk("R9", "stopped valid", int'(freq_valid), 0, 0);
        chk("R5", "stopped offset", int'(freq_offset), 0, 0);

        // R1 reset mid-run, then a silent first window
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "idx after reset", int'(freq_idx), 15, 0);
        chk("R1", "valid after reset", int'(freq_valid), 0, 0);
        chk("R1", "offset after reset", int'(freq_offset), 0, 0);
        rst = 1'b0;
        seen = 0;
        for (int c = 0; c < WIN + 20; c++) begin
            @(negedge clk);
            if (meas_done) seen++;
        end
        chk("R1", "early report", seen, 0, 0);

        summary();
        $finish;
    end

endmodule